// File: doc/BRIEF.md
# I2C Register Byte Access Engine

This block sits between a register client and a byte-level I2C master. Each client request reads or writes one 8-bit register of a single target. The target has a fixed 7-bit bus address. The engine expands each request into the bus commands the master executes: start, address byte, data bytes, read byte and stop. It collects one response per command and returns a one-cycle completion pulse carrying the read byte and an error flag.

A register write is a single bus transfer. A register read is always two bus transfers. The first writes the register pointer and ends with a stop. The second reads one byte. No repeated start is used. The engine keeps a flag that records whether the most recent finished transfer was a read. When that flag is set, the next write transfer is held back by a guard delay. The delay is derived from the clock frequency parameter. A read that fails, or that returns all ones, is repeated up to a bounded number of attempts. The data FIFO register is the exception and is read only once.

Both sides use valid/ready handshakes. The request side accepts one request at a time. `req_ready` drops at acceptance and rises again in the cycle that carries the completion pulse, so a client holding `req_valid` is simply stalled. On the command side, `cmd_valid`, `cmd_op` and `cmd_byte` stay stable until `cmd_ready`. The master then returns exactly one `rsp_valid` pulse for that command before the next command is offered. The completion output and the response input are plain pulses with no back-pressure.

Top module: `i2c_regbyte_engine`

## Requirements
- R1: Out of reset `req_ready` is high, `cmd_valid` is low and `done_valid` is low. After a request is accepted, `req_ready` stays low until the cycle in which `done_valid` pulses.
- R2: A register write issues, in order: START, WRITE 0x40 (target address 0x20 with the direction bit 0), WRITE register address, WRITE data, STOP. Command codes on `cmd_op` are START=0, WRITE=1, READ=2, STOP=3.
- R3: One read attempt issues, in order: START, WRITE 0x40, WRITE register address, STOP, START, WRITE 0x41, READ, STOP. The READ response data is the register value.
- R4: When the last finished transfer was a read, the START of the next transfer is issued no earlier than GUARD cycles after that read's STOP response. This applies to new requests and to the address phase of a retried read. GUARD is CLK_FREQ_HZ/1000*GUARD_US/1000, and at least 1.
- R5: When the last finished transfer was a write, or no transfer has finished since reset, the next transfer is not delayed by the guard.
- R6: A read attempt with any `rsp_err`, or whose value is 0xFF, is repeated. At most 3 attempts are made in total.
- R7: A read of the FIFO register at address 0x05 is made exactly once, whatever it returns.
- R8: A read whose final attempt had an error reports `done_rdata` = 0xFF.
- R9: `done_err` is set when the final read attempt had an error, unless the register is the access register at address 0x00. For a write, `done_err` is set when any write-transfer response had an error.
- R10: `done_valid` lasts exactly one cycle per request. For a write, `done_rdata` is 0x00.
- R11: `cmd_valid`, `cmd_op` and `cmd_byte` hold steady while `cmd_ready` is low. The next command is offered only after the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_write | input | 1 | 1 for register write, 0 for register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Byte to write |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 8 | Read result (0x00 for writes) |
| done_err | output | 1 | Request failed |
| cmd_valid | output | 1 | Bus command valid |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_op | output | 2 | Command code: START, WRITE, READ, STOP |
| cmd_byte | output | 8 | Byte for a WRITE command |
| rsp_valid | input | 1 | One-cycle response for the accepted command |
| rsp_data | input | 8 | Byte returned by a READ command |
| rsp_err | input | 1 | Command failed (no acknowledge or bus error) |

## Verification
The assertions assume the master behaves well. It returns exactly one `rsp_valid` pulse per accepted command, never before the handshake. It keeps `rsp_valid` low otherwise, and the client only raises requests that the handshake accepts. The bench master model answers each command exactly once, after a random delay of zero to two cycles. Its ready delay is also random, so no response overlaps a pending command. The bench shrinks the guard by passing a small frequency parameter, so that many retried reads fit in a short run.

// File: rtl/i2c_regbyte_pkg.sv
package i2c_regbyte_pkg;

  localparam int BYTE_W = 8;
  localparam int STEP_W = 3;

  // Last step index of each request kind
  localparam int WR_LAST_STEP = 4;
  localparam int RD_LAST_STEP = 7;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_ISSUE,
    ST_WAIT,
    ST_DECIDE
  } eng_state_e;

  typedef struct packed {
    bus_op_e             op;
    logic [BYTE_W-1:0]   byte_val;
    logic                last;          // final step of this attempt
    logic                ends_wr_xfer;  // STOP closing a write transfer
    logic                ends_rd_xfer;  // STOP closing a read transfer
    logic                is_read;       // the READ byte step
  } step_t;

endpackage

// File: rtl/regbyte_step_decoder.sv
module regbyte_step_decoder
  import i2c_regbyte_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20
) (
  input  logic              is_write,
  input  logic [STEP_W-1:0] step,
  input  logic [BYTE_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] wdata,
  output step_t             cur
);

  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] ADDR_RD = {DEV_ADDR, 1'b1};

  always_comb begin
    cur = '0;
    cur.op = OP_START;
    if (is_write) begin
      case (step)
        3'd0: cur.op = OP_START;
        3'd1: begin cur.op = OP_WRITE; cur.byte_val = ADDR_WR;  end
        3'd2: begin cur.op = OP_WRITE; cur.byte_val = reg_addr; end
        3'd3: begin cur.op = OP_WRITE; cur.byte_val = wdata;    end
        default: begin
          cur.op           = OP_STOP;
          cur.last         = 1'b1;
          cur.ends_wr_xfer = 1'b1;
        end
      endcase
    end else begin
      case (step)
        3'd0: cur.op = OP_START;
        3'd1: begin cur.op = OP_WRITE; cur.byte_val = ADDR_WR;  end
        3'd2: begin cur.op = OP_WRITE; cur.byte_val = reg_addr; end
        3'd3: begin cur.op = OP_STOP;  cur.ends_wr_xfer = 1'b1; end
        3'd4: cur.op = OP_START;
        3'd5: begin cur.op = OP_WRITE; cur.byte_val = ADDR_RD;  end
        3'd6: begin cur.op = OP_READ;  cur.is_read = 1'b1;      end
        default: begin
          cur.op           = OP_STOP;
          cur.last         = 1'b1;
          cur.ends_rd_xfer = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/regbyte_guard_timer.sv
module regbyte_guard_timer #(
  parameter int GUARD_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,        // start a guard window
  input  logic mark_read,   // a read transfer just finished
  input  logic mark_write,  // a write transfer just finished
  output logic prev_read,
  output logic expired
);

  localparam int CNT_W = (GUARD_CYCLES < 2) ? 1 : $clog2(GUARD_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(GUARD_CYCLES - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_read <= 1'b0;
    end else if (mark_read) begin
      prev_read <= 1'b1;
    end else if (mark_write) begin
      prev_read <= 1'b0;
    end
  end

  assign expired = (cnt == '0);

  // R5: a finished write transfer leaves no pending guard flag
  a_r5_flag_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_write && !mark_read) |=> !prev_read);

endmodule

// File: rtl/regbyte_attempt_tracker.sv
module regbyte_attempt_tracker
  import i2c_regbyte_pkg::*;
#(
  parameter int                MAX_ATTEMPTS = 3,
  parameter logic [BYTE_W-1:0] FIFO_REG     = 8'h05,
  parameter logic [BYTE_W-1:0] ACCESS_REG   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bump,
  input  logic              is_write,
  input  logic [BYTE_W-1:0] reg_addr,
  input  logic              fail,
  input  logic [BYTE_W-1:0] rbyte,
  output logic              retry,
  output logic [BYTE_W-1:0] final_val,
  output logic              final_err
);

  localparam int ATT_W = (MAX_ATTEMPTS < 2) ? 1 : $clog2(MAX_ATTEMPTS + 1);
  localparam logic [BYTE_W-1:0] ALL_ONES = '1;

  logic [ATT_W-1:0] used;  // attempts already repeated
  logic             more_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
    end else if (clear) begin
      used <= '0;
    end else if (bump) begin
      used <= used + ATT_W'(1);
    end
  end

  assign more_left = (used < ATT_W'(MAX_ATTEMPTS - 1));
  assign final_val = fail ? ALL_ONES : rbyte;
  assign retry     = !is_write && (final_val == ALL_ONES) &&
                     (reg_addr != FIFO_REG) && more_left;
  assign final_err = fail && (is_write || (reg_addr != ACCESS_REG));

  // R6: never more attempts than allowed
  a_r6_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    used < ATT_W'(MAX_ATTEMPTS));

  // R6: only reads are repeated
  a_r6_bump_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !is_write);

  // R7: the FIFO register never sees a second attempt
  a_r7_fifo_single: assert property (@(posedge clk) disable iff (!rst_n)
    (used != '0) |-> (reg_addr != FIFO_REG));

endmodule

// File: rtl/i2c_regbyte_engine.sv
module i2c_regbyte_engine
  import i2c_regbyte_pkg::*;
#(
  parameter int                CLK_FREQ_HZ  = 125_000_000,
  parameter int                GUARD_US     = 250,
  parameter logic [6:0]        DEV_ADDR     = 7'h20,
  parameter int                MAX_ATTEMPTS = 3,
  parameter logic [BYTE_W-1:0] FIFO_REG     = 8'h05,
  parameter logic [BYTE_W-1:0] ACCESS_REG   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BYTE_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              done_valid,
  output logic [BYTE_W-1:0] done_rdata,
  output logic              done_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  input  logic              rsp_err
);

  localparam int RAW_GUARD    = ((CLK_FREQ_HZ / 1000) * GUARD_US) / 1000;
  localparam int GUARD_CYCLES = (RAW_GUARD < 1) ? 1 : RAW_GUARD;
  localparam int GAP_W        = $clog2(GUARD_CYCLES + 1) + 1;

  eng_state_e        state;
  logic [STEP_W-1:0] step;
  logic              wr_q;
  logic [BYTE_W-1:0] reg_q;
  logic [BYTE_W-1:0] data_q;
  logic              fail_q;
  logic [BYTE_W-1:0] rbyte_q;

  step_t             cur;
  logic              prev_read;
  logic              guard_done;
  logic              retry;
  logic [BYTE_W-1:0] final_val;
  logic              final_err;

  logic              accept;
  logic              rsp_take;
  logic              do_retry;
  logic              start_seq;
  logic              go_guard;
  logic              mark_read;
  logic              mark_write;

  regbyte_step_decoder #(
    .DEV_ADDR (DEV_ADDR)
  ) u_steps (
    .is_write (wr_q),
    .step     (step),
    .reg_addr (reg_q),
    .wdata    (data_q),
    .cur      (cur)
  );

  regbyte_guard_timer #(
    .GUARD_CYCLES (GUARD_CYCLES)
  ) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (go_guard),
    .mark_read  (mark_read),
    .mark_write (mark_write),
    .prev_read  (prev_read),
    .expired    (guard_done)
  );

  regbyte_attempt_tracker #(
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .FIFO_REG     (FIFO_REG),
    .ACCESS_REG   (ACCESS_REG)
  ) u_attempts (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .bump      (do_retry),
    .is_write  (wr_q),
    .reg_addr  (reg_q),
    .fail      (fail_q),
    .rbyte     (rbyte_q),
    .retry     (retry),
    .final_val (final_val),
    .final_err (final_err)
  );

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_ready && req_valid;
  assign rsp_take   = (state == ST_WAIT) && rsp_valid;
  assign do_retry   = (state == ST_DECIDE) && retry;
  assign start_seq  = accept || do_retry;
  assign go_guard   = start_seq && prev_read;
  assign mark_read  = rsp_take && cur.ends_rd_xfer;
  assign mark_write = rsp_take && cur.ends_wr_xfer;

  assign cmd_valid  = (state == ST_ISSUE);
  assign cmd_op     = cur.op;
  assign cmd_byte   = cur.byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      step       <= '0;
      wr_q       <= 1'b0;
      reg_q      <= '0;
      data_q     <= '0;
      fail_q     <= 1'b0;
      rbyte_q    <= '0;
      done_valid <= 1'b0;
      done_rdata <= '0;
      done_err   <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            wr_q    <= req_write;
            reg_q   <= req_addr;
            data_q  <= req_wdata;
            step    <= '0;
            fail_q  <= 1'b0;
            rbyte_q <= '0;
            state   <= go_guard ? ST_GUARD : ST_ISSUE;
          end
        end
        ST_GUARD: begin
          if (guard_done) state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (cmd_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err)     fail_q  <= 1'b1;
            if (cur.is_read) rbyte_q <= rsp_data;
            if (cur.last) begin
              state <= ST_DECIDE;
            end else begin
              step  <= step + STEP_W'(1);
              state <= ST_ISSUE;
            end
          end
        end
        ST_DECIDE: begin
          if (retry) begin
            step    <= '0;
            fail_q  <= 1'b0;
            rbyte_q <= '0;
            state   <= go_guard ? ST_GUARD : ST_ISSUE;
          end else begin
            done_valid <= 1'b1;
            done_rdata <= wr_q ? '0 : final_val;
            done_err   <= final_err;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Cycles elapsed since the last read transfer closed (saturating)
  logic [GAP_W-1:0] rd_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_gap <= '0;
    end else if (mark_read) begin
      rd_gap <= '0;
    end else if (rd_gap < GAP_W'(GUARD_CYCLES)) begin
      rd_gap <= rd_gap + GAP_W'(1);
    end
  end

  // R1: busy from acceptance onward
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11: a pending command holds steady
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  // R4: a transfer following a read is held back by the guard window
  a_r4_guard_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_START) && prev_read) |-> (rd_gap >= GAP_W'(GUARD_CYCLES)));

  // R10: completion lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R8: a flagged read failure carries all ones
  a_r8_fail_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_err && (done_rdata != '0)) |-> (done_rdata == 8'hFF));

endmodule

// File: tb/test_i2c_regbyte_engine.sv
module test_i2c_regbyte_engine;
  import i2c_regbyte_pkg::*;

  localparam int G = 50;  // guard cycles for CLK_FREQ_HZ=200_000, GUARD_US=250

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_write;
  logic [7:0] req_addr, req_wdata;
  logic       done_valid, done_err;
  logic [7:0] done_rdata;
  logic       cmd_valid, cmd_ready;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       rsp_valid, rsp_err;
  logic [7:0] rsp_data;

  always #4 clk = ~clk;  // 125 MHz

  i2c_regbyte_engine #(.CLK_FREQ_HZ(200_000)) i_i2c_regbyte_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .done_valid(done_valid), .done_rdata(done_rdata), .done_err(done_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scripted target behaviour
  logic [7:0] scr_val [3];
  logic       scr_err [3];
  logic       wr_err_inj;
  int         rd_idx;

  // Observed and expected command streams
  logic [1:0] log_op [32];
  logic [7:0] log_b  [32];
  int         log_n;
  logic [1:0] exp_op [32];
  logic [7:0] exp_b  [32];
  int         exp_n;

  bit prev_read = 1'b0;
  bit seen_stop = 1'b0;
  bit cur_read  = 1'b0;
  int last_stop_cyc = 0;
  int byte_idx = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b);
    exp_op[exp_n] = op;
    exp_b[exp_n]  = b;
    exp_n++;
  endtask

  // Master model: one response per accepted command
  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [1:0] op0;
        logic [7:0] b0;
        logic [7:0] d;
        logic       e;
        int         gap;
        op0 = cmd_op; b0 = cmd_byte; d = '0; e = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(cmd_valid && cmd_op == op0 && cmd_byte == b0, "R11 command held",
            {cmd_op, cmd_byte}, {op0, b0});
        cmd_ready = 1'b1;
        if (log_n < 32) begin log_op[log_n] = op0; log_b[log_n] = b0; end
        log_n++;
        if (op0 == OP_START) begin
          byte_idx = 0;
          gap = cyc - last_stop_cyc;
          if (seen_stop && prev_read)
            chk(gap >= G && gap <= G + 12, "R4 guard after read", gap, G);
          else if (seen_stop)
            chk(gap <= 12, "R5 no guard after write", gap, 12);
        end
        if (op0 == OP_WRITE) begin
          if (byte_idx == 0) cur_read = b0[0];
          if (byte_idx == 2 && !cur_read) e = wr_err_inj;
          byte_idx++;
        end
        if (op0 == OP_READ) begin
          if (rd_idx < 3) begin d = scr_val[rd_idx]; e = scr_err[rd_idx]; end
          else begin d = 8'hFF; e = 1'b1; end
          rd_idx++;
        end
        @(negedge clk);
        cmd_ready = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rsp_valid = 1'b1; rsp_data = d; rsp_err = e;
        if (op0 == OP_STOP) begin
          last_stop_cyc = cyc;
          prev_read = cur_read;
          seen_stop = 1'b1;
        end
        @(negedge clk);
        rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
      end
    end
  end

  task automatic set_rd(input logic [7:0] v0, input logic e0, input logic [7:0] v1,
                        input logic e1, input logic [7:0] v2, input logic e2);
    scr_val[0] = v0; scr_err[0] = e0;
    scr_val[1] = v1; scr_err[1] = e1;
    scr_val[2] = v2; scr_err[2] = e2;
  endtask

  task automatic run_req(input bit wr, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] erd;
    logic [7:0] val;
    bit         eerr;
    bit         fl;
    bit         ok;
    int         wait_n;
    string      tag;
    exp_n = 0; erd = '0; eerr = 1'b0; fl = 1'b0; val = '0;
    if (wr) begin
      push(OP_START, 8'h00); push(OP_WRITE, 8'h40); push(OP_WRITE, a);
      push(OP_WRITE, d); push(OP_STOP, 8'h00);
      eerr = wr_err_inj;
      tag = "R2 write sequence";
    end else begin
      for (int k = 0; k < 3; k++) begin
        push(OP_START, 8'h00); push(OP_WRITE, 8'h40); push(OP_WRITE, a); push(OP_STOP, 8'h00);
        push(OP_START, 8'h00); push(OP_WRITE, 8'h41); push(OP_READ, 8'h00); push(OP_STOP, 8'h00);
        fl  = scr_err[k];
        val = fl ? 8'hFF : scr_val[k];
        if (val != 8'hFF || a == 8'h05) break;
      end
      erd  = val;
      eerr = fl && (a != 8'h00);
      tag = (a == 8'h05) ? "R7 fifo single attempt" : "R3 R6 read sequence and retries";
    end
    log_n = 0; rd_idx = 0;
    @(negedge clk);
    chk(req_ready, "R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 busy after accept", req_ready, 0);
    wait_n = 0;
    while (!done_valid && wait_n < 3000) begin @(negedge clk); wait_n++; end
    if (!done_valid) begin
      chk(1'b0, "R10 completion missing", 0, 1);
    end else begin
      chk(done_rdata == erd, wr ? "R10 write data zero" : "R8 read data", done_rdata, erd);
      chk(done_err == eerr, "R9 error flag", done_err, eerr);
      ok = (log_n == exp_n);
      for (int k = 0; k < 32; k++)
        if (ok && k < exp_n && (log_op[k] != exp_op[k] || log_b[k] != exp_b[k])) ok = 1'b0;
      chk(ok, tag, log_n, exp_n);
      @(negedge clk);
      chk(!done_valid, "R10 completion one cycle", done_valid, 0);
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] pick [7];
    void'($urandom(32'd7319));
    pick[0] = 8'h00; pick[1] = 8'h01; pick[2] = 8'h02; pick[3] = 8'h03;
    pick[4] = 8'h05; pick[5] = 8'h09; pick[6] = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    wr_err_inj = 1'b0; log_n = 0; rd_idx = 0; exp_n = 0;
    set_rd(8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    repeat (5) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1 reset no command", cmd_valid, 0);
    chk(done_valid == 1'b0, "R1 reset no completion", done_valid, 0);
    rst_n = 1'b1;

    // Directed corner cases
    run_req(1'b1, 8'h01, 8'h40);                                        // R2
    set_rd(8'h81, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0); run_req(1'b0, 8'h01, 8'h00); // R3
    run_req(1'b1, 8'h01, 8'h20);                                        // R4 write after read
    set_rd(8'hFF, 1'b0, 8'hFF, 1'b0, 8'hFF, 1'b0); run_req(1'b0, 8'h01, 8'h00); // R6 cap
    set_rd(8'hFF, 1'b0, 8'h5A, 1'b0, 8'h00, 1'b0); run_req(1'b0, 8'h02, 8'h00); // R6 recover
    set_rd(8'h00, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1); run_req(1'b0, 8'h03, 8'h00); // R8 R9
    set_rd(8'h00, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1); run_req(1'b0, 8'h00, 8'h00); // R9 access
    set_rd(8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0); run_req(1'b0, 8'h05, 8'h00); // R7
    set_rd(8'h11, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0); run_req(1'b0, 8'h05, 8'h00); // R7 R9
    set_rd(8'h33, 1'b1, 8'h44, 1'b0, 8'h00, 1'b0); run_req(1'b0, 8'h09, 8'h00); // R6 after fail
    wr_err_inj = 1'b1; run_req(1'b1, 8'h05, 8'hC3); wr_err_inj = 1'b0;   // R9 R10
    run_req(1'b1, 8'h02, 8'h01);                                        // R5 write after write

    // Constrained random traffic
    for (int n = 0; n < 40; n++) begin
      bit         wr;
      logic [7:0] a;
      logic [7:0] v [3];
      logic       e [3];
      wr = ($urandom_range(0, 1) == 1);
      pick[6] = 8'($urandom_range(0, 255));
      a = pick[$urandom_range(0, 6)];
      for (int k = 0; k < 3; k++) begin
        v[k] = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
        e[k] = ($urandom_range(0, 5) == 0);
      end
      set_rd(v[0], e[0], v[1], e[1], v[2], e[2]);
      wr_err_inj = wr && ($urandom_range(0, 7) == 0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      run_req(wr, a, 8'($urandom_range(0, 255)));
      wr_err_inj = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule